// File: doc/BRIEF.md
# Instruction Fetch Array with Per-Byte Access Gating

This block is the data array of an instruction cache. Each entry holds one 32-bit instruction, stored as four independent 8-bit lanes. Lane 3 holds bits 31:24, lane 2 holds bits 23:16, lane 1 holds bits 15:8 and lane 0 holds bits 7:0. Each lane has its own access enable, so a fetch touches only the lanes that carry information.

The two upper lanes are gated by value. When an instruction is filled, each of them is checked for being all zeros. The result is kept as one indicator bit per lane. A lane whose indicator is set is neither written nor read.

The two lower lanes are gated by use. A two-bit length code arrives with the instruction on the fill interface and is stored alongside it. The code classes the instruction as short, medium or long, and it decides whether lanes 1 and 0 take part in the access. Any lane left out of a fetch reads back as 0x00.

Fetch data appears one cycle after the request. Two counters report how many lane accesses were skipped, one for each gating rule.

Top module: `ifetch_gate_array`

## Requirements
- R1: An upper lane (lane 3 = bits 31:24, lane 2 = bits 23:16) filled with 0x00 reads back as 0x00, and each such lane adds 1 to `zero_skip_cnt` on every fetch of that entry.
- R2: An upper lane filled with a non-zero byte is returned unchanged in its bit positions on fetch.
- R3: The length code `fill_len` = 2'b00 (short) makes lanes 1 and 0 read as 0x00 whatever bytes were filled. The code 2'b01 is also treated as short.
- R4: The length code 2'b10 (medium) returns lane 1 (bits 15:8) as filled and reads lane 0 (bits 7:0) as 0x00.
- R5: The length code 2'b11 (long) returns both lanes 1 and 0 as filled.
- R6: A fetch sampled at a rising edge with `fetch_en` = 1 drives `fetch_valid` = 1 and the gated word on `fetch_instr` after that same edge, that is, one cycle after the request.
- R7: A cycle without a fetch drives `fetch_valid` = 0 and `fetch_instr` = 0 after the next edge, and leaves both counters unchanged.
- R8: Each fetch adds to `len_skip_cnt` the number of lower lanes left unused by the stored code: 2 for short, 1 for medium, 0 for long.
- R9: After reset both counters are 0. Every entry that has not been filled reads as 0x00000000, counting 2 zero-skips and 2 length-skips per fetch.
- R10: A fill and a fetch to the same address in the same cycle return the entry's previous contents. The new contents are seen from the next fetch on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Write one instruction into the array |
| fill_addr | input | ADDR_W | Entry index for the fill |
| fill_instr | input | 32 | Instruction word to store |
| fill_len | input | 2 | Length code: bit 1 enables lane 1, bits 1 and 0 together enable lane 0 |
| fetch_en | input | 1 | Fetch request |
| fetch_addr | input | ADDR_W | Entry index for the fetch |
| fetch_instr | output | 32 | Gated instruction word; lanes not accessed read 0 |
| fetch_valid | output | 1 | High in the cycle after a fetch request |
| zero_skip_cnt | output | CNT_W | Upper-lane accesses skipped by zero indication |
| len_skip_cnt | output | CNT_W | Lower-lane accesses skipped by the length code |

## Verification
Every fetch result and both counter updates are due exactly one cycle after the request. The driver applies the request at a falling edge, and a matching expected item is queued at the same moment. The monitor compares the word and the running counter totals at the following falling edge, so the registered outputs are read half a cycle after the capturing edge. Idle cycles are checked at the falling edge after the edge that follows them, so the cleared valid, the zero word and the unchanged counters are all observed at the ports. The same-cycle fill-and-fetch case computes its expected value from the model before the model takes the fill.

// File: rtl/ifga_pkg.sv
package ifga_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    // per-entry side information kept next to the data lanes
    typedef struct packed {
        logic [1:0] zind;   // [1] lane 3 zero, [0] lane 2 zero
        logic [1:0] len;    // [1] lane 1 used, [0] lane 0 used when [1] set
    } meta_t;

    localparam meta_t META_RST = '{zind: 2'b11, len: 2'b00};
endpackage

// File: rtl/ifga_lane_bank.sv
module ifga_lane_bank #(
    parameter int DEPTH  = 16,
    parameter int W      = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    typedef struct packed {
        logic [W-1:0] dout;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.dout = rd_en ? mem[rd_addr] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = st_q.dout;
endmodule

// File: rtl/ifga_lane_gate.sv
module ifga_lane_gate
    import ifga_pkg::*;
(
    input  logic [WORD_W-1:0] fill_instr,
    input  logic [1:0]        fill_len,
    input  meta_t             rd_meta,
    output meta_t             wr_meta,
    output logic [LANES-1:0]  wr_lane_en,
    output logic [LANES-1:0]  rd_lane_en,
    output logic [1:0]        zero_skips,
    output logic [1:0]        len_skips
);
    logic lo1_rd, lo0_rd;

    always_comb begin
        wr_meta.zind[1] = (fill_instr[31:24] == '0);
        wr_meta.zind[0] = (fill_instr[23:16] == '0);
        wr_meta.len     = fill_len;

        wr_lane_en[3] = !wr_meta.zind[1];
        wr_lane_en[2] = !wr_meta.zind[0];
        wr_lane_en[1] = fill_len[1];
        wr_lane_en[0] = fill_len[1] & fill_len[0];

        lo1_rd = rd_meta.len[1];
        lo0_rd = rd_meta.len[1] & rd_meta.len[0];

        rd_lane_en = {!rd_meta.zind[1], !rd_meta.zind[0], lo1_rd, lo0_rd};

        zero_skips = {1'b0, rd_meta.zind[1]} + {1'b0, rd_meta.zind[0]};
        len_skips  = {1'b0, !lo1_rd} + {1'b0, !lo0_rd};
    end
endmodule

// File: rtl/ifetch_gate_array.sv
module ifetch_gate_array
    import ifga_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [31:0]       fill_instr,
    input  logic [1:0]        fill_len,
    input  logic              fetch_en,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [31:0]       fetch_instr,
    output logic              fetch_valid,
    output logic [CNT_W-1:0]  zero_skip_cnt,
    output logic [CNT_W-1:0]  len_skip_cnt
);
    typedef struct packed {
        logic             vld;
        logic [CNT_W-1:0] zcnt;
        logic [CNT_W-1:0] lcnt;
    } top_st_t;

    top_st_t st_d, st_q;
    meta_t   meta_d [DEPTH];
    meta_t   meta_q [DEPTH];

    meta_t            wr_meta;
    logic [LANES-1:0] wr_lane_en, rd_lane_en;
    logic [1:0]       zero_skips, len_skips;
    logic [LANE_W-1:0] lane_out [LANES];

    ifga_lane_gate u_gate (
        .fill_instr (fill_instr),
        .fill_len   (fill_len),
        .rd_meta    (meta_q[fetch_addr]),
        .wr_meta    (wr_meta),
        .wr_lane_en (wr_lane_en),
        .rd_lane_en (rd_lane_en),
        .zero_skips (zero_skips),
        .len_skips  (len_skips)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ifga_lane_bank #(.DEPTH(DEPTH), .W(LANE_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (fill_en & wr_lane_en[g]),
            .wr_addr (fill_addr),
            .wr_data (fill_instr[g*LANE_W +: LANE_W]),
            .rd_en   (fetch_en & rd_lane_en[g]),
            .rd_addr (fetch_addr),
            .rd_data (lane_out[g])
        );
        assign fetch_instr[g*LANE_W +: LANE_W] = lane_out[g];
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = fetch_en;
        if (fetch_en) begin
            st_d.zcnt = st_q.zcnt + CNT_W'(zero_skips);
            st_d.lcnt = st_q.lcnt + CNT_W'(len_skips);
        end
        for (int i = 0; i < DEPTH; i++) meta_d[i] = meta_q[i];
        if (fill_en) meta_d[fill_addr] = wr_meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) meta_q[i] <= META_RST;
        end else begin
            st_q <= st_d;
            for (int i = 0; i < DEPTH; i++) meta_q[i] <= meta_d[i];
        end
    end

    assign fetch_valid   = st_q.vld;
    assign zero_skip_cnt = st_q.zcnt;
    assign len_skip_cnt  = st_q.lcnt;
endmodule

// File: rtl/ifga_chk.sv
module ifga_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_en,
    input logic             fetch_valid,
    input logic [31:0]      fetch_instr,
    input logic [CNT_W-1:0] zero_skip_cnt,
    input logic [CNT_W-1:0] len_skip_cnt
);
    // R6
    fetch_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |=> fetch_valid);

    // R7
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en |=> !fetch_valid);

    // R7
    idle_zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> fetch_instr == '0);

    // R7
    idle_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en |=> ($stable(zero_skip_cnt) && $stable(len_skip_cnt)));

    // R1
    zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |=> (CNT_W'(zero_skip_cnt - $past(zero_skip_cnt)) <= CNT_W'(2)));

    // R8
    len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |=> (CNT_W'(len_skip_cnt - $past(len_skip_cnt)) <= CNT_W'(2)));
endmodule

bind ifetch_gate_array ifga_chk #(.CNT_W(CNT_W)) u_ifga_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_en      (fetch_en),
    .fetch_valid   (fetch_valid),
    .fetch_instr   (fetch_instr),
    .zero_skip_cnt (zero_skip_cnt),
    .len_skip_cnt  (len_skip_cnt)
);

// File: tb/test_ifetch_gate_array.sv
module test_ifetch_gate_array;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = 16;

    logic clk = 0, rst_n = 0;
    logic fill_en = 0, fetch_en = 0;
    logic [AW-1:0] fill_addr = '0, fetch_addr = '0;
    logic [31:0] fill_instr = '0;
    logic [1:0]  fill_len = '0;
    logic [31:0] fetch_instr;
    logic        fetch_valid;
    logic [CNT_W-1:0] zero_skip_cnt, len_skip_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifetch_gate_array #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_ifetch_gate_array (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_instr(fill_instr), .fill_len(fill_len),
        .fetch_en(fetch_en), .fetch_addr(fetch_addr),
        .fetch_instr(fetch_instr), .fetch_valid(fetch_valid),
        .zero_skip_cnt(zero_skip_cnt), .len_skip_cnt(len_skip_cnt)
    );

    int n_chk = 0, n_bad = 0;
    logic [31:0] m_word [DEPTH];
    logic [1:0]  m_len  [DEPTH];
    int exp_z = 0, exp_l = 0;

    logic [31:0] q_word [$];
    int          q_z [$];
    int          q_l [$];
    string       q_tag [$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected word from requirements R1-style value gating and R3/R4/R5 length codes
    function automatic logic [31:0] gated(logic [31:0] w, logic [1:0] l);
        logic [31:0] r;
        r = w;
        if (!l[1])          r[15:8] = 8'h00;
        if (!(l[1] & l[0])) r[7:0]  = 8'h00;
        return r;
    endfunction

    // one cycle of stimulus: expected item computed before model takes the fill (R10)
    task automatic step(bit do_fill, int fa, logic [31:0] fw, logic [1:0] fl,
                        bit do_fetch, int ra, string tag);
        @(negedge clk);
        if (do_fetch) begin
            exp_z += (m_word[ra][31:24] == 8'h00) + (m_word[ra][23:16] == 8'h00);
            exp_l += (!m_len[ra][1]) + (!(m_len[ra][1] & m_len[ra][0]));
            q_word.push_back(gated(m_word[ra], m_len[ra]));
            q_z.push_back(exp_z);
            q_l.push_back(exp_l);
            q_tag.push_back(tag);
        end
        if (do_fill) begin
            m_word[fa] = fw;
            m_len[fa]  = fl;
        end
        fill_en    = do_fill;
        fill_addr  = AW'(fa);
        fill_instr = fw;
        fill_len   = fl;
        fetch_en   = do_fetch;
        fetch_addr = AW'(ra);
    endtask

    task automatic fill(int a, logic [31:0] w, logic [1:0] l);
        step(1, a, w, l, 0, 0, "");
    endtask

    task automatic fetch(int a, string tag);
        step(0, 0, 32'h0, 2'b00, 1, a, tag);
    endtask

    // monitor: R6, results due one cycle after the request
    always @(negedge clk) begin
        if (rst_n && fetch_valid) begin
            if (q_word.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R6 unexpected valid actual=1 expected=0");
            end else begin
                string t;
                t = q_tag.pop_front();
                check({t, " R6 word"}, fetch_instr, q_word.pop_front());
                check({t, " R8 zero count"}, 32'(zero_skip_cnt), 32'(q_z.pop_front()));
                check({t, " R8 len count"}, 32'(len_skip_cnt), 32'(q_l.pop_front()));
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_word[i] = '0;
            m_len[i]  = 2'b00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        check("R9 reset valid", 32'(fetch_valid), 32'd0);
        check("R9 reset word", fetch_instr, 32'd0);
        check("R9 reset zero count", 32'(zero_skip_cnt), 32'd0);
        check("R9 reset len count", 32'(len_skip_cnt), 32'd0);

        fetch(3, "R9 unfilled entry");
        fill(0, 32'h1234_5678, 2'b11);
        fill(1, 32'h00AB_CDEF, 2'b10);
        fill(2, 32'h0000_FFFF, 2'b00);
        fill(3, 32'hA500_1122, 2'b01);
        fill(4, 32'h5A5A_5A5A, 2'b11);
        fetch(0, "R5 R2 long");
        fetch(1, "R4 R1 medium");
        fetch(2, "R3 R1 short");
        fetch(3, "R3 code 01 short");
        step(1, 4, 32'h0102_0304, 2'b11, 1, 4, "R10 same-cycle old");
        fetch(4, "R10 new contents");
        fill(0, 32'h1234_5678, 2'b00);
        fetch(0, "R3 overwrite short");
        fetch(15, "R9 unfilled high entry");
        fill(5, 32'h0077_0000, 2'b10);
        fetch(5, "R1 R4 lane3 zero");

        // R7 idle cycles
        step(0, 0, 32'h0, 2'b00, 0, 0, "");
        step(0, 0, 32'h0, 2'b00, 0, 0, "");
        @(negedge clk);
        check("R7 idle valid", 32'(fetch_valid), 32'd0);
        check("R7 idle word", fetch_instr, 32'd0);
        check("R7 idle zero count", 32'(zero_skip_cnt), 32'(exp_z));
        check("R7 idle len count", 32'(len_skip_cnt), 32'(exp_l));
        check("R6 queue drained", 32'(q_word.size()), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule